// File: doc/BRIEF.md
# Scan-out Frame Pointer Controller

This block is the register front end of a pixel buffer video output. It keeps two frame buffer base addresses, a displayed one and a drawing one, and hands the displayed address plus a fetch enable to the scan engine that reads pixels from memory. Software talks to it through four 32-bit word registers on a simple register bus with read and write strobes and a two-bit word index.

Software never loads the displayed address directly. It draws into the buffer named by the drawing address, then writes any value to word 0. That write only arms an exchange of the two addresses and raises a pending flag in the status word. The exchange is carried out in a single clock when the scan engine signals the end of the current frame, so the picture never changes mid-frame. Software polls the pending flag until it clears and may then reuse the old displayed buffer for drawing.

Word 2 reports the fixed active resolution, and word 3 reads as a status word and is written as a control word whose only live bit turns pixel fetching on or off.

Top module: `scanout_ptr_ctrl`

## Requirements
- R1: After reset, both the displayed and the drawing address are 0x0800_0000, fetching is enabled (`scan_enable` = 1), the pending flag is 0 and `bus_rdata` is 0.
- R2: A write to word 0, whatever its data, leaves the displayed address unchanged and sets the pending flag (status bit 0) on the next clock.
- R3: When `frame_done` is high while the pending flag is 1, the displayed and drawing addresses exchange in that clock and the pending flag returns to 0.
- R4: A write to word 0 while the pending flag is already 1 keeps exactly one pending exchange; the next `frame_done` performs one exchange, not none.
- R5: A write to word 0 in the same clock as `frame_done` is taken at that boundary: the addresses exchange and the pending flag ends at 0.
- R6: Word 1 reads back the drawing address and a write to it loads the full 32-bit value; if that write meets an exchange in the same clock, the displayed address takes the old drawing address and the drawing address takes the written data.
- R7: Word 2 reads 240 in bits 31:16 and 320 in bits 15:0; writes to word 2 change nothing.
- R8: Writing word 3 sets the fetch enable to data bit 2 and ignores every other data bit; the enable appears on `scan_enable` and in status bit 2 on the next clock.
- R9: The status word reads bit 1 = 0 (padded addressing), bits 7:6 = 1 (bytes per pixel minus one), bits 11:8 = 15 (pixel bits minus one), bits 23:16 = 9 (column address bits), bits 31:24 = 8 (row address bits), and 0 in bits 5:3 and 15:12.
- R10: `bus_rdata` is registered: it shows the addressed word one clock after `bus_rd` and holds that value while `bus_rd` is low.
- R11: `frame_done` with no pending flag and no word 0 write leaves both addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word index: 0 displayed, 1 drawing, 2 resolution, 3 status/control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| frame_done | input | 1 | One-clock pulse from the scan engine at the end of each frame |
| scan_base | output | 32 | Displayed buffer base address for the scan engine |
| scan_enable | output | 1 | Pixel fetch enable for the scan engine |

## Verification
The bound checker watches every clock for the exchange rules: a word 0 write never moves the displayed address by itself, a pending exchange survives until a frame end, the frame end with a pending or coincident request delivers the old drawing address and clears the flag, an idle frame end moves nothing, and the enable follows control bit 2. The bench alone can show the read side: the exact bit layout of the status and resolution words, the one-clock read latency and hold, the priority of a drawing-address write against a simultaneous exchange, and long random mixes of requests, writes and frame ends compared with a reference model.

// File: rtl/scanout_pkg.sv
package scanout_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    REG_SHOWN  = 2'd0,
    REG_DRAW   = 2'd1,
    REG_RESOL  = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT = 2;
endpackage

// File: rtl/scanout_swap_ptrs.sv
module scanout_swap_ptrs #(
  parameter int                     PTR_W     = 32,
  parameter logic [PTR_W-1:0]       RESET_PTR = 32'h0800_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             swap_req,
  input  logic             draw_wr,
  input  logic [PTR_W-1:0] draw_wdata,
  input  logic             frame_done,
  output logic [PTR_W-1:0] shown_q,
  output logic [PTR_W-1:0] draw_q,
  output logic             pend_q
);
  logic do_swap;

  // exchange fires at a frame end if armed earlier or armed this very clock
  assign do_swap = frame_done && (pend_q || swap_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      shown_q <= RESET_PTR;
      draw_q  <= RESET_PTR;
      pend_q  <= 1'b0;
    end else begin
      if (do_swap) begin
        shown_q <= draw_q;
        draw_q  <= draw_wr ? draw_wdata : shown_q;
        pend_q  <= 1'b0;
      end else begin
        if (draw_wr) draw_q <= draw_wdata;
        if (swap_req) pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scanout_ctrl.sv
module scanout_ctrl #(
  parameter logic EN_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic en_bit,
  output logic en_q
);
  always_ff @(posedge clk) begin
    if (rst)          en_q <= EN_RESET;
    else if (ctrl_wr) en_q <= en_bit;
  end
endmodule

// File: rtl/scanout_rd_mux.sv
module scanout_rd_mux
  import scanout_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  reg_sel_e          sel,
  input  logic [WORD_W-1:0] shown,
  input  logic [WORD_W-1:0] draw,
  input  logic [WORD_W-1:0] resol,
  input  logic [WORD_W-1:0] status,
  output logic [WORD_W-1:0] rdata_q
);
  logic [WORD_W-1:0] pick;

  always_comb begin
    unique case (sel)
      REG_SHOWN: pick = shown;
      REG_DRAW:  pick = draw;
      REG_RESOL: pick = resol;
      default:   pick = status;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= pick;
  end
endmodule

// File: rtl/scanout_ptr_ctrl.sv
module scanout_ptr_ctrl
  import scanout_pkg::*;
#(
  parameter logic [31:0] RESET_PTR = 32'h0800_0000,
  parameter int          H_ACTIVE  = 320,
  parameter int          V_ACTIVE  = 240,
  parameter int          PIX_BITS  = 16,
  parameter int          COL_AW    = 9,
  parameter int          ROW_AW    = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        frame_done,
  output logic [31:0] scan_base,
  output logic        scan_enable
);
  localparam int          PIX_BYTES = PIX_BITS / 8;
  localparam logic [15:0] RES_COLS  = 16'(H_ACTIVE);
  localparam logic [15:0] RES_ROWS  = 16'(V_ACTIVE);
  localparam logic [3:0]  BS_FIELD  = 4'(PIX_BITS - 1);
  localparam logic [1:0]  SB_FIELD  = 2'(PIX_BYTES - 1);
  localparam logic [7:0]  COL_FIELD = 8'(COL_AW);
  localparam logic [7:0]  ROW_FIELD = 8'(ROW_AW);

  reg_sel_e    sel;
  logic        wr_shown, wr_draw, wr_ctrl;
  logic [31:0] shown_q, back_q;
  logic        swap_pend, en_q;
  logic [31:0] resol_word, status_word;

  assign sel      = reg_sel_e'(bus_addr);
  assign wr_shown = bus_wr && (sel == REG_SHOWN);
  assign wr_draw  = bus_wr && (sel == REG_DRAW);
  assign wr_ctrl  = bus_wr && (sel == REG_STATUS);

  scanout_swap_ptrs #(.PTR_W(WORD_W), .RESET_PTR(RESET_PTR)) ptrs_i (
    .clk        (clk),
    .rst        (rst),
    .swap_req   (wr_shown),
    .draw_wr    (wr_draw),
    .draw_wdata (bus_wdata),
    .frame_done (frame_done),
    .shown_q    (shown_q),
    .draw_q     (back_q),
    .pend_q     (swap_pend)
  );

  scanout_ctrl #(.EN_RESET(1'b1)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .ctrl_wr (wr_ctrl),
    .en_bit  (bus_wdata[CTRL_EN_BIT]),
    .en_q    (en_q)
  );

  assign resol_word  = {RES_ROWS, RES_COLS};
  assign status_word = {ROW_FIELD, COL_FIELD, 4'b0, BS_FIELD, SB_FIELD,
                        3'b0, en_q, 1'b0, swap_pend};

  scanout_rd_mux rd_i (
    .clk     (clk),
    .rst     (rst),
    .rd      (bus_rd),
    .sel     (sel),
    .shown   (shown_q),
    .draw    (back_q),
    .resol   (resol_word),
    .status  (status_word),
    .rdata_q (bus_rdata)
  );

  assign scan_base   = shown_q;
  assign scan_enable = en_q;
endmodule

// File: rtl/scanout_ptr_ctrl_chk.sv
module scanout_ptr_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        frame_done,
  input logic [31:0] scan_base,
  input logic        scan_enable,
  input logic        swap_pending,
  input logic [31:0] back_ptr
);
  logic req;
  assign req = bus_wr && (bus_addr == 2'd0);

  assert_hold_shown_R2: assert property (@(posedge clk) disable iff (rst)
    (req && !frame_done) |=> ($stable(scan_base) && swap_pending));

  assert_swap_at_end_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_done && swap_pending) |=> (scan_base == $past(back_ptr) && !swap_pending));

  assert_keep_pending_R4: assert property (@(posedge clk) disable iff (rst)
    (swap_pending && !frame_done) |=> swap_pending);

  assert_same_clock_R5: assert property (@(posedge clk) disable iff (rst)
    (frame_done && req) |=> (scan_base == $past(back_ptr) && !swap_pending));

  assert_enable_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd3) |=> (scan_enable == $past(bus_wdata[2])));

  assert_idle_end_R11: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !swap_pending && !req) |=> $stable(scan_base));
endmodule

bind scanout_ptr_ctrl scanout_ptr_ctrl_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .frame_done   (frame_done),
  .scan_base    (scan_base),
  .scan_enable  (scan_enable),
  .swap_pending (swap_pend),
  .back_ptr     (back_q)
);

// File: tb/scanout_ptr_ctrl_tb_top.sv
`timescale 1ns/1ps
module scanout_ptr_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, frame_done = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, scan_base;
  logic        scan_enable;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [31:0] m_shown, m_draw, m_rd;
  logic        m_en, m_pend;

  always #2.5 clk = ~clk;

  scanout_ptr_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done(frame_done),
    .scan_base(scan_base), .scan_enable(scan_enable)
  );

  function automatic logic [31:0] read_exp(input logic [1:0] a);
    case (a)
      2'd0:    return m_shown;
      2'd1:    return m_draw;
      2'd2:    return {16'd240, 16'd320};
      default: return {8'd8, 8'd9, 4'b0, 4'd15, 2'd1, 3'b0, m_en, 1'b0, m_pend};
    endcase
  endfunction

  task automatic model_step(input logic wr, input logic [1:0] a,
                            input logic [31:0] d, input logic fd);
    logic req, swp;
    logic [31:0] old_shown;
    req = wr && a == 2'd0;
    swp = fd && (m_pend || req);
    old_shown = m_shown;
    if (swp) begin
      m_shown = m_draw;
      m_draw  = (wr && a == 2'd1) ? d : old_shown;
      m_pend  = 1'b0;
    end else begin
      if (wr && a == 2'd1) m_draw = d;
      if (req) m_pend = 1'b1;
    end
    if (wr && a == 2'd3) m_en = d[2];
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic rd, input logic [1:0] a,
                     input logic [31:0] d, input logic fd, input string tag);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; frame_done = fd;
    if (rd) m_rd = read_exp(a);
    model_step(wr, a, d, fd);
    @(posedge clk);
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0; frame_done = 1'b0;
    check({tag, " scan_base"}, scan_base, m_shown);
    check({tag, " scan_enable"}, {31'b0, scan_enable}, {31'b0, m_en});
    check({tag, " rdata (R10)"}, bus_rdata, m_rd);
  endtask

  task automatic rd_reg(input logic [1:0] a, input string tag);
    cyc(1'b0, 1'b1, a, 32'h0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240211));
    m_shown = 32'h0800_0000; m_draw = 32'h0800_0000;
    m_en = 1'b1; m_pend = 1'b0; m_rd = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check("R1 scan_base", scan_base, 32'h0800_0000);
    check("R1 scan_enable", {31'b0, scan_enable}, 32'd1);
    check("R1 rdata", bus_rdata, 32'h0);
    rd_reg(2'd0, "R1"); rd_reg(2'd1, "R1"); rd_reg(2'd3, "R1");
    // R6 drawing address write and read back
    cyc(1'b1, 1'b0, 2'd1, 32'h0123_4000, 1'b0, "R6");
    rd_reg(2'd1, "R6");
    // R2 request does not load data
    cyc(1'b1, 1'b0, 2'd0, 32'hDEAD_BEEF, 1'b0, "R2");
    rd_reg(2'd0, "R2"); rd_reg(2'd3, "R2");
    // R4 repeated request, single exchange
    cyc(1'b1, 1'b0, 2'd0, 32'h1, 1'b0, "R4");
    cyc(1'b0, 1'b0, 2'd0, 32'h0, 1'b1, "R4");
    check("R4 shown after one swap", scan_base, 32'h0123_4000);
    rd_reg(2'd3, "R4"); rd_reg(2'd1, "R4");
    // R11 idle frame end
    cyc(1'b0, 1'b0, 2'd0, 32'h0, 1'b1, "R11");
    cyc(1'b0, 1'b0, 2'd0, 32'h0, 1'b1, "R11");
    // R5 request in the frame-end clock
    cyc(1'b1, 1'b0, 2'd0, 32'h0, 1'b1, "R5");
    check("R5 shown", scan_base, 32'h0800_0000);
    rd_reg(2'd3, "R5");
    // R6 drawing write meets exchange
    cyc(1'b1, 1'b0, 2'd0, 32'h0, 1'b0, "R6");
    cyc(1'b1, 1'b0, 2'd1, 32'h0200_0000, 1'b1, "R6");
    check("R6 shown takes old draw", scan_base, 32'h0123_4000);
    rd_reg(2'd1, "R6");
    // R7 resolution ignores writes
    cyc(1'b1, 1'b0, 2'd2, 32'hFFFF_FFFF, 1'b0, "R7");
    rd_reg(2'd2, "R7");
    check("R7 resolution word", bus_rdata, {16'd240, 16'd320});
    // R8 enable control
    cyc(1'b1, 1'b0, 2'd3, 32'h0, 1'b0, "R8");
    cyc(1'b1, 1'b0, 2'd3, 32'hFFFF_FFFB, 1'b0, "R8");
    check("R8 other bits ignored", {31'b0, scan_enable}, 32'd0);
    rd_reg(2'd3, "R8");
    cyc(1'b1, 1'b0, 2'd3, 32'h4, 1'b0, "R8");
    // R9 status constants
    rd_reg(2'd3, "R9");
    check("R9 status word", bus_rdata, 32'h0809_0F44);
    // R10 hold while idle
    repeat (3) cyc(1'b0, 1'b0, 2'd0, 32'h0, 1'b0, "R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] & r[1], r[2], r[4:3], {$urandom} & 32'hFFFF_FFFC,
          (r[7:5] == 3'd0), "R3 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule